// File: doc/BRIEF.md
# Paged PHY-Register to OCP Address Translator

This block sits between a PHY management port that speaks in 5-bit register numbers with 16-bit data and a flat 16-bit OCP register space. It keeps one base address. A write to the page-select register (number 0x1F) only updates that base and goes no further. Every other access, including a read of 0x1F, becomes one OCP access whose byte address comes from the base and the register number.

While the base equals the standard window (0xA400), register `n` maps to `base + 2*n`. For any other base the register number first drops by 0x10, so the upper half of the register numbers lands at the start of the selected page. Writing zero to the page-select register returns to the standard window. Only one forwarded access is in flight at a time. Its response comes back upstream one cycle after the OCP side answers. A read that times out returns all ones.

Top module: `mdio_ocp_xlate`

## Requirements
- R1: After reset the base is 0xA400, `up_resp_valid` is low, `oc_valid` is low while `up_valid` is low, and the first read of register 2 goes to OCP address 0xA404.
- R2: A write to register 0x1F never raises `oc_valid`. It completes with `up_resp_valid` high in the cycle after acceptance, with `up_rdata` = 0.
- R3: An accepted write of value `v` to register 0x1F sets the base to `(v << 4) mod 2^16` when `v` is nonzero, and to 0xA400 when `v` is zero.
- R4: While the base equals 0xA400, register `n` maps to OCP address `0xA400 + 2*n`. This also holds when the base reached 0xA400 through a nonzero page value (0x0A40).
- R5: While the base differs from 0xA400, register `n` maps to `(base + 2*(n - 0x10)) mod 2^16`. The arithmetic wraps for `n < 0x10` and for bases near 0xFFFF.
- R6: A read of register 0x1F is forwarded with the same mapping as any other register.
- R7: `up_ready` is high only when `oc_ready` is high and no forwarded access is outstanding. After a forwarded access is accepted, `up_ready` stays low until its response has been received.
- R8: One cycle after `oc_resp_valid` for an outstanding read without error, `up_resp_valid` pulses and `up_rdata` equals `oc_resp_data`.
- R9: When a forwarded read ends with `oc_resp_err` high, `up_rdata` is 0xFFFF.
- R10: A forwarded write presents `oc_we` = 1 and `oc_wdata` equal to `up_wdata`. Its completion carries `up_rdata` = 0, with or without an error.
- R11: A request accepted in the cycle directly after a page-select write is mapped with the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted this cycle if valid |
| up_we | input | 1 | 1 = write, 0 = read |
| up_reg | input | 5 | PHY register number |
| up_wdata | input | 16 | Write data |
| up_resp_valid | output | 1 | One-cycle completion pulse |
| up_rdata | output | 16 | Read data for the completed access (0 for writes) |
| oc_valid | output | 1 | OCP request valid |
| oc_ready | input | 1 | OCP port can take a request |
| oc_we | output | 1 | OCP write enable |
| oc_addr | output | 16 | OCP byte address |
| oc_wdata | output | 16 | OCP write data |
| oc_resp_valid | input | 1 | OCP access finished |
| oc_resp_data | input | 16 | OCP read data |
| oc_resp_err | input | 1 | OCP access timed out |

## Verification
Two things can fall in the same cycle: the completion of a page-select write and the acceptance and mapping of the next request. The bench provokes this by issuing a request in the very cycle in which the page write reports completion. It then checks that the forwarded address already uses the new base. A second overlap is a response arriving in the cycle right after acceptance, and random zero-latency responses provoke it. The bench also mixes random page values (zero, 0x0A40, wrap-prone values) with stalls on `oc_ready`, and computes every address from its own model of the base.

// File: rtl/mdio_ocp_xlate.sv
module mdio_ocp_xlate #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int RW = 5,
  parameter logic [RW-1:0] PAGE_REG = '1,
  parameter logic [AW-1:0] STD_BASE = 16'hA400,
  parameter int PAGE_SHIFT = 4,
  parameter int HI_OFS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic          up_we,
  input  logic [RW-1:0] up_reg,
  input  logic [DW-1:0] up_wdata,
  output logic          up_resp_valid,
  output logic [DW-1:0] up_rdata,
  output logic          oc_valid,
  input  logic          oc_ready,
  output logic          oc_we,
  output logic [AW-1:0] oc_addr,
  output logic [DW-1:0] oc_wdata,
  input  logic          oc_resp_valid,
  input  logic [DW-1:0] oc_resp_data,
  input  logic          oc_resp_err
);

  logic [AW-1:0] base_q;
  logic          busy_q;
  logic          wr_q;
  logic          rv_q;
  logic [DW-1:0] rd_q;

  logic          is_page;
  logic          accept;
  logic [AW-1:0] reg_ext;
  logic [AW-1:0] reg_adj;
  logic [AW-1:0] page_base;

  assign is_page   = up_we && (up_reg == PAGE_REG);
  assign up_ready  = !busy_q && oc_ready;
  assign accept    = up_valid && up_ready;
  assign reg_ext   = AW'(up_reg);
  assign reg_adj   = (base_q == STD_BASE) ? reg_ext : reg_ext - AW'(HI_OFS);
  assign page_base = (up_wdata == '0) ? STD_BASE : (AW'(up_wdata) << PAGE_SHIFT);

  assign oc_valid = up_valid && !busy_q && !is_page;
  assign oc_we    = up_we;
  assign oc_addr  = base_q + (reg_adj << 1);
  assign oc_wdata = up_wdata;

  assign up_resp_valid = rv_q;
  assign up_rdata      = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= STD_BASE;
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      rv_q   <= 1'b0;
      rd_q   <= '0;
    end else begin
      rv_q <= 1'b0;
      if (accept && is_page) begin
        base_q <= page_base;
        rv_q   <= 1'b1;
        rd_q   <= '0;
      end else if (accept) begin
        busy_q <= 1'b1;
        wr_q   <= up_we;
      end
      if (busy_q && oc_resp_valid) begin
        busy_q <= 1'b0;
        rv_q   <= 1'b1;
        rd_q   <= wr_q ? '0 : (oc_resp_err ? '1 : oc_resp_data);
      end
    end
  end

endmodule

// File: rtl/mdio_ocp_xlate_chk.sv
module mdio_ocp_xlate_chk #(
  parameter int DW = 16,
  parameter int RW = 5,
  parameter logic [RW-1:0] PAGE_REG = '1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          up_valid,
  input logic          up_ready,
  input logic          up_we,
  input logic [RW-1:0] up_reg,
  input logic          up_resp_valid,
  input logic [DW-1:0] up_rdata,
  input logic          oc_valid,
  input logic          oc_ready,
  input logic          oc_resp_valid,
  input logic          oc_resp_err,
  input logic          busy,
  input logic          wr
);

  AST_PAGE_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_ready && up_we && up_reg == PAGE_REG |-> !oc_valid); // R2

  AST_PAGE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_ready && up_we && up_reg == PAGE_REG |=> up_resp_valid && up_rdata == '0); // R2

  AST_ACCEPT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_ready |-> oc_ready); // R7

  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    oc_valid && oc_ready |=> !up_ready); // R7

  AST_TIMEOUT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !wr && oc_resp_valid && oc_resp_err |=> up_resp_valid && up_rdata == '1); // R9

  AST_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr && oc_resp_valid |=> up_resp_valid && up_rdata == '0); // R10

endmodule

bind mdio_ocp_xlate mdio_ocp_xlate_chk #(.DW(DW), .RW(RW), .PAGE_REG(PAGE_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
  .up_we(up_we), .up_reg(up_reg), .up_resp_valid(up_resp_valid),
  .up_rdata(up_rdata), .oc_valid(oc_valid), .oc_ready(oc_ready),
  .oc_resp_valid(oc_resp_valid), .oc_resp_err(oc_resp_err),
  .busy(busy_q), .wr(wr_q)
);

// File: tb/tb_mdio_ocp_xlate.sv
module tb_mdio_ocp_xlate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_valid = 1'b0, up_we = 1'b0;
  logic [4:0] up_reg = '0;
  logic [15:0] up_wdata = '0;
  logic up_ready, up_resp_valid, oc_valid, oc_we;
  logic [15:0] up_rdata, oc_addr, oc_wdata;
  logic oc_ready = 1'b1, oc_resp_valid = 1'b0, oc_resp_err = 1'b0;
  logic [15:0] oc_resp_data = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [15:0] mb = 16'hA400;
  localparam logic [15:0] KEY = 16'h3C5A;

  always #4 clk = ~clk;

  mdio_ocp_xlate dut (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
    .up_we(up_we), .up_reg(up_reg), .up_wdata(up_wdata),
    .up_resp_valid(up_resp_valid), .up_rdata(up_rdata),
    .oc_valid(oc_valid), .oc_ready(oc_ready), .oc_we(oc_we),
    .oc_addr(oc_addr), .oc_wdata(oc_wdata), .oc_resp_valid(oc_resp_valid),
    .oc_resp_data(oc_resp_data), .oc_resp_err(oc_resp_err)
  );

  function automatic logic [15:0] exp_addr(input logic [15:0] b, input logic [4:0] r);
    logic [15:0] n = {11'd0, r};
    if (b != 16'hA400) n = n - 16'h10;
    return b + (n << 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic txn(input bit we, input logic [4:0] r, input logic [15:0] wd,
                     input int stall, input int lat, input bit err, input string tag);
    bit pg = we && (r == 5'h1F);
    logic [15:0] ea = exp_addr(mb, r);
    logic [15:0] ed;
    string t;
    up_valid = 1'b1; up_we = we; up_reg = r; up_wdata = wd;
    for (int i = 0; i < stall; i++) begin
      oc_ready = 1'b0; #1;
      chk(up_ready === 1'b0, "R7", {15'd0, up_ready}, 16'd0);
      @(negedge clk);
    end
    oc_ready = 1'b1; #1;
    chk(up_ready === 1'b1, "R7", {15'd0, up_ready}, 16'd1);
    if (pg) begin
      chk(oc_valid === 1'b0, "R2", {15'd0, oc_valid}, 16'd0);
    end else begin
      t = (tag != "") ? tag : (r == 5'h1F) ? "R6" : (mb == 16'hA400) ? "R4" : "R5";
      chk(oc_valid === 1'b1 && oc_addr === ea, t, oc_addr, ea);
      if (we) chk(oc_we === 1'b1 && oc_wdata === wd, "R10", oc_wdata, wd);
    end
    @(negedge clk);
    up_valid = 1'b0;
    if (pg) begin
      chk(up_resp_valid === 1'b1 && up_rdata === 16'd0, "R2", up_rdata, 16'd0);
      mb = (wd == 16'd0) ? 16'hA400 : (wd << 4);
    end else begin
      for (int i = 0; i < lat; i++) begin
        chk(up_ready === 1'b0 && up_resp_valid === 1'b0, "R7", {15'd0, up_ready}, 16'd0);
        @(negedge clk);
      end
      oc_resp_valid = 1'b1; oc_resp_data = ea ^ KEY; oc_resp_err = err;
      @(negedge clk);
      oc_resp_valid = 1'b0; oc_resp_err = 1'b0;
      ed = we ? 16'd0 : (err ? 16'hFFFF : ea ^ KEY);
      chk(up_resp_valid === 1'b1 && up_rdata === ed,
          we ? "R10" : (err ? "R9" : "R8"), up_rdata, ed);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1971));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(up_resp_valid === 1'b0, "R1", {15'd0, up_resp_valid}, 16'd0);
    chk(oc_valid === 1'b0, "R1", {15'd0, oc_valid}, 16'd0);
    @(negedge clk);
    txn(1'b0, 5'd2, 16'd0, 0, 1, 1'b0, "R1");
    txn(1'b0, 5'h1F, 16'd0, 1, 0, 1'b0, "R6");
    txn(1'b1, 5'd7, 16'h1234, 2, 2, 1'b0, "");
    txn(1'b1, 5'h1F, 16'h0A43, 0, 0, 1'b0, "");
    txn(1'b0, 5'h10, 16'd0, 0, 0, 1'b0, "R11");
    txn(1'b0, 5'h00, 16'd0, 0, 1, 1'b0, "R5");
    txn(1'b0, 5'h1F, 16'd0, 0, 1, 1'b1, "R6");
    txn(1'b1, 5'h1F, 16'hFFFF, 0, 0, 1'b0, "");
    txn(1'b0, 5'h1F, 16'd0, 0, 0, 1'b0, "R3");
    txn(1'b0, 5'h05, 16'd0, 0, 0, 1'b1, "R5");
    txn(1'b1, 5'h12, 16'hBEEF, 0, 0, 1'b1, "");
    txn(1'b1, 5'h1F, 16'h0A40, 0, 0, 1'b0, "");
    txn(1'b0, 5'h03, 16'd0, 0, 0, 1'b0, "R4");
    txn(1'b1, 5'h1F, 16'h0BC4, 1, 0, 1'b0, "");
    txn(1'b0, 5'h10, 16'd0, 0, 2, 1'b0, "R3");
    txn(1'b1, 5'h1F, 16'h0000, 0, 0, 1'b0, "");
    txn(1'b0, 5'h01, 16'd0, 0, 0, 1'b0, "R3");
    for (int k = 0; k < 400; k++) begin
      bit we = $urandom_range(0, 1) == 1;
      logic [4:0] r = 5'($urandom_range(0, 31));
      logic [15:0] wd = 16'($urandom);
      int sel = $urandom_range(0, 7);
      if (sel == 0) begin
        we = 1'b1; r = 5'h1F;
        case ($urandom_range(0, 3))
          0: wd = 16'h0000;
          1: wd = 16'h0A40;
          2: wd = 16'hFFF0 | 16'($urandom_range(0, 15));
          default: wd = 16'($urandom);
        endcase
      end
      txn(we, r, wd, $urandom_range(0, 2), $urandom_range(0, 3),
          $urandom_range(0, 7) == 0, "");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule